// File: doc/BRIEF.md
# Level-1 Vector Base Register Access Controller

This block holds the exception vector base used when an exception is taken to privilege level 1, together with the level-2 vector base that the same instructions can reach when the hypervisor runs in host mode. Each cycle it may see one system-register move instruction, already split into its encoding fields, with a read or write direction, the current privilege level and a set of hypervisor control inputs. It decides the result of that instruction: undefined, a trap to level 2 with a syndrome class, a redirect to a fixed memory slot, an access to the level-2 register, or a direct access to the level-1 register.

Two encodings name the register. The main one differs from the second one only in its op1 field. Whether the current level, the host-mode bit and the three nested-virtualization bits permit a given access depends on which of the two encodings is used. Writes change a register only when the decision is a register access. Reads return the chosen register with the 11 reserved low bits at zero. The memory transaction and the exception entry are left to the surrounding logic.

Top module: `vbase_access_ctl`

## Requirements
- R1: The main encoding is op0=2'b11, op1=3'b000, CRn=4'b1100, CRm=4'b0000, op2=3'b000. The second encoding is the same with op1=3'b101. When `acc_valid` is low or no encoding matches, `hit` is 0, `outcome` is 0 and neither register changes.
- R2: `outcome` is one-hot or zero. Bit 0 means undefined, bit 1 trap, bit 2 memory redirect, bit 3 level-2 register access and bit 4 direct level-1 register access.
- R3: At level 0 every matched access through either encoding is undefined.
- R4: At level 1 with the main encoding, nested bits 3'b011 give a trap. Otherwise, if the fine-grained check of R5 does not trap, 3'b111 gives a memory redirect and any other value gives a direct access.
- R5: At level 1 with the main encoding and nested bits other than 3'b011, the access traps when level 2 is enabled, fine-grained traps are implemented, either level 3 is absent or its fine-grained enable is set, and the trap bit for the access direction is set. Reads use `fg_rd_trap` and writes use `fg_wr_trap`.
- R6: At level 1 with the second encoding, nested bits 3'b101 give a memory redirect. Otherwise nested bit 0 set gives a trap, and every other case is undefined.
- R7: At level 2 with the main encoding, host mode gives a level-2 register access. Without host mode the result is a direct access.
- R8: At levels 2 and 3 with the second encoding, host mode gives a direct access. Without host mode the result is undefined.
- R9: At level 3 the main encoding always gives a direct access.
- R10: A trap drives `syn_class` to 6'h18. A memory redirect drives `mem_offset` to 12'h250. Both outputs are zero for all other results.
- R11: A write with a direct result loads the level-1 register on the clock edge, and a write with a level-2 result loads the level-2 register. Bits [10:0] are stored as zero. Undefined, trap and redirect results change neither register.
- R12: Reset clears both registers to zero.
- R13: `rdata` carries the register chosen by a read with a direct or level-2 result, and is zero otherwise. Bits [10:0] of `rdata` are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | A register move instruction is present |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| enc_op0 | input | 2 | Encoding field op0 |
| enc_op1 | input | 3 | Encoding field op1 |
| enc_crn | input | 4 | Encoding field CRn |
| enc_crm | input | 4 | Encoding field CRm |
| enc_op2 | input | 3 | Encoding field op2 |
| cur_lvl | input | 2 | Current privilege level, 0 to 3 |
| host_mode | input | 1 | Hypervisor host mode is active |
| nv_bits | input | 3 | Nested-virtualization triple |
| lvl2_en | input | 1 | Level 2 is enabled |
| fgt_impl | input | 1 | Fine-grained traps are implemented |
| lvl3_present | input | 1 | Level 3 is implemented |
| lvl3_fgt_en | input | 1 | Fine-grained enable set by level 3 |
| fg_rd_trap | input | 1 | Fine-grained read trap bit |
| fg_wr_trap | input | 1 | Fine-grained write trap bit |
| wdata | input | 64 | Write data |
| hit | output | 1 | A valid access matched one of the two encodings |
| outcome | output | 5 | One-hot result |
| syn_class | output | 6 | Syndrome class on a trap |
| mem_offset | output | 12 | Memory slot offset on a redirect |
| rdata | output | 64 | Read data |
| base_l1 | output | 64 | Level-1 vector base register |
| base_l2 | output | 64 | Level-2 vector base register |

## Verification
The assertions check on every cycle that `outcome` is one-hot or zero, that level 0 never gets anything but an undefined result, that level 3 with the main encoding always gets a direct access, that the syndrome class and memory offset agree with the result, that the reserved read bits stay zero, and that results which are not register accesses leave both registers unchanged on the next edge. The bench covers what depends on the full decision order: how the nested triple ranks against the fine-grained trap gate, which register host mode selects at each level, and whether the data written lands in the correct register, with the level-2 register reachable only through level 2 in host mode. The bench compares every access against a reference decision function over random and directed stimulus.

// File: rtl/vbase_pkg.sv
package vbase_pkg;
  localparam int OC_N      = 5;
  localparam int OC_UNDEF  = 0;
  localparam int OC_TRAP   = 1;
  localparam int OC_MEM    = 2;
  localparam int OC_ALIAS  = 3;
  localparam int OC_DIRECT = 4;

  typedef logic [OC_N-1:0] oc_vec_t;

  typedef enum logic [1:0] {
    LVL0 = 2'd0,
    LVL1 = 2'd1,
    LVL2 = 2'd2,
    LVL3 = 2'd3
  } lvl_e;
endpackage

// File: rtl/vbase_decode.sv
module vbase_decode
  import vbase_pkg::*;
#(
  parameter int          SYN_W     = 6,
  parameter int          OFF_W     = 12,
  parameter logic [5:0]  SYN_TRAP  = 6'h18,
  parameter logic [11:0] MEM_SLOT  = 12'h250
) (
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic [1:0]       enc_op0,
  input  logic [2:0]       enc_op1,
  input  logic [3:0]       enc_crn,
  input  logic [3:0]       enc_crm,
  input  logic [2:0]       enc_op2,
  input  logic [1:0]       cur_lvl,
  input  logic             host_mode,
  input  logic [2:0]       nv_bits,
  input  logic             lvl2_en,
  input  logic             fgt_impl,
  input  logic             lvl3_present,
  input  logic             lvl3_fgt_en,
  input  logic             fg_rd_trap,
  input  logic             fg_wr_trap,
  output logic             hit,
  output oc_vec_t          outcome,
  output logic [SYN_W-1:0] syn_class,
  output logic [OFF_W-1:0] mem_offset
);
  logic common_match, is_main, is_alt, fgt_gate, fgt_fire;
  lvl_e lvl;

  assign lvl          = lvl_e'(cur_lvl);
  assign common_match = (enc_op0 == 2'b11) && (enc_crn == 4'b1100) &&
                        (enc_crm == 4'b0000) && (enc_op2 == 3'b000);
  assign is_main      = common_match && (enc_op1 == 3'b000);
  assign is_alt       = common_match && (enc_op1 == 3'b101);
  assign hit          = acc_valid && (is_main || is_alt);
  assign fgt_gate     = lvl2_en && fgt_impl && (!lvl3_present || lvl3_fgt_en);
  assign fgt_fire     = fgt_gate && (acc_write ? fg_wr_trap : fg_rd_trap);

  always_comb begin
    outcome = '0;
    if (hit) begin
      unique case (lvl)
        LVL0: outcome[OC_UNDEF] = 1'b1;
        LVL1: begin
          if (is_main) begin
            if (nv_bits == 3'b011)      outcome[OC_TRAP]   = 1'b1;
            else if (fgt_fire)          outcome[OC_TRAP]   = 1'b1;
            else if (nv_bits == 3'b111) outcome[OC_MEM]    = 1'b1;
            else                        outcome[OC_DIRECT] = 1'b1;
          end else begin
            if (nv_bits == 3'b101)      outcome[OC_MEM]    = 1'b1;
            else if (nv_bits[0])        outcome[OC_TRAP]   = 1'b1;
            else                        outcome[OC_UNDEF]  = 1'b1;
          end
        end
        LVL2: begin
          if (is_main) begin
            if (host_mode) outcome[OC_ALIAS]  = 1'b1;
            else           outcome[OC_DIRECT] = 1'b1;
          end else begin
            if (host_mode) outcome[OC_DIRECT] = 1'b1;
            else           outcome[OC_UNDEF]  = 1'b1;
          end
        end
        LVL3: begin
          if (is_main || host_mode) outcome[OC_DIRECT] = 1'b1;
          else                      outcome[OC_UNDEF]  = 1'b1;
        end
        default: outcome = '0;
      endcase
    end
  end

  assign syn_class  = outcome[OC_TRAP] ? SYN_W'(SYN_TRAP) : '0;
  assign mem_offset = outcome[OC_MEM]  ? OFF_W'(MEM_SLOT) : '0;
endmodule

// File: rtl/vbase_store.sv
module vbase_store #(
  parameter int DATA_W   = 64,
  parameter int RSV_BITS = 11,
  localparam int BASE_W  = DATA_W - RSV_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_l1,
  input  logic              wr_l2,
  input  logic [BASE_W-1:0] wbase,
  output logic [DATA_W-1:0] base_l1,
  output logic [DATA_W-1:0] base_l2
);
  logic [BASE_W-1:0] l1_q, l1_d, l2_q, l2_d;

  always_comb begin
    l1_d = l1_q;
    l2_d = l2_q;
    if (wr_l1) l1_d = wbase;
    if (wr_l2) l2_d = wbase;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l1_q <= '0;
      l2_q <= '0;
    end else begin
      if (wr_l1) l1_q <= l1_d;
      if (wr_l2) l2_q <= l2_d;
    end
  end

  assign base_l1 = {l1_q, {RSV_BITS{1'b0}}};
  assign base_l2 = {l2_q, {RSV_BITS{1'b0}}};
endmodule

// File: rtl/vbase_access_ctl.sv
module vbase_access_ctl
  import vbase_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int RSV_BITS = 11,
  parameter int SYN_W    = 6,
  parameter int OFF_W    = 12,
  localparam int BASE_W  = DATA_W - RSV_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [1:0]        enc_op0,
  input  logic [2:0]        enc_op1,
  input  logic [3:0]        enc_crn,
  input  logic [3:0]        enc_crm,
  input  logic [2:0]        enc_op2,
  input  logic [1:0]        cur_lvl,
  input  logic              host_mode,
  input  logic [2:0]        nv_bits,
  input  logic              lvl2_en,
  input  logic              fgt_impl,
  input  logic              lvl3_present,
  input  logic              lvl3_fgt_en,
  input  logic              fg_rd_trap,
  input  logic              fg_wr_trap,
  input  logic [DATA_W-1:0] wdata,
  output logic              hit,
  output logic [OC_N-1:0]   outcome,
  output logic [SYN_W-1:0]  syn_class,
  output logic [OFF_W-1:0]  mem_offset,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] base_l1,
  output logic [DATA_W-1:0] base_l2
);
  oc_vec_t oc;
  logic    wr_l1, wr_l2;
  logic    unused_low;

  vbase_decode #(.SYN_W(SYN_W), .OFF_W(OFF_W)) u_dec (
    .acc_valid(acc_valid), .acc_write(acc_write),
    .enc_op0(enc_op0), .enc_op1(enc_op1), .enc_crn(enc_crn),
    .enc_crm(enc_crm), .enc_op2(enc_op2), .cur_lvl(cur_lvl),
    .host_mode(host_mode), .nv_bits(nv_bits), .lvl2_en(lvl2_en),
    .fgt_impl(fgt_impl), .lvl3_present(lvl3_present),
    .lvl3_fgt_en(lvl3_fgt_en), .fg_rd_trap(fg_rd_trap),
    .fg_wr_trap(fg_wr_trap), .hit(hit), .outcome(oc),
    .syn_class(syn_class), .mem_offset(mem_offset)
  );

  assign wr_l1 = acc_write && oc[OC_DIRECT];
  assign wr_l2 = acc_write && oc[OC_ALIAS];

  vbase_store #(.DATA_W(DATA_W), .RSV_BITS(RSV_BITS)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_l1(wr_l1), .wr_l2(wr_l2),
    .wbase(wdata[DATA_W-1:RSV_BITS]),
    .base_l1(base_l1), .base_l2(base_l2)
  );

  always_comb begin
    rdata = '0;
    if (!acc_write && oc[OC_DIRECT]) rdata = base_l1;
    if (!acc_write && oc[OC_ALIAS])  rdata = base_l2;
  end

  assign outcome    = oc;
  assign unused_low = ^wdata[RSV_BITS-1:0];
endmodule

// File: rtl/vbase_access_chk.sv
module vbase_access_chk #(
  parameter int DATA_W   = 64,
  parameter int RSV_BITS = 11,
  parameter int SYN_W    = 6,
  parameter int OFF_W    = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_write,
  input logic [2:0]        enc_op1,
  input logic [1:0]        cur_lvl,
  input logic              hit,
  input logic [4:0]        outcome,
  input logic [SYN_W-1:0]  syn_class,
  input logic [OFF_W-1:0]  mem_offset,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic [DATA_W-1:0] base_l1,
  input logic [DATA_W-1:0] base_l2
);
  AST_OUTCOME_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(outcome)); // R2
  AST_NOHIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> outcome == 5'b0); // R1
  AST_LVL0_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cur_lvl == 2'd0) |-> outcome == 5'b00001); // R3
  AST_LVL3_MAIN_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cur_lvl == 2'd3 && enc_op1 == 3'b000) |-> outcome == 5'b10000); // R9
  AST_TRAP_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    outcome[1] ? (syn_class == SYN_W'(6'h18)) : (syn_class == '0)); // R10
  AST_MEM_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    outcome[2] ? (mem_offset == OFF_W'(12'h250)) : (mem_offset == '0)); // R10
  AST_NO_REG_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (outcome[2:0] != 3'b0 || !acc_valid) |=> ($stable(base_l1) && $stable(base_l2))); // R11
  AST_DIRECT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_write && outcome[4]) |=>
      base_l1[DATA_W-1:RSV_BITS] == $past(wdata[DATA_W-1:RSV_BITS])); // R11
  AST_RDATA_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[RSV_BITS-1:0] == '0); // R13
endmodule

bind vbase_access_ctl vbase_access_chk #(
  .DATA_W(DATA_W), .RSV_BITS(RSV_BITS), .SYN_W(SYN_W), .OFF_W(OFF_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
  .enc_op1(enc_op1), .cur_lvl(cur_lvl), .hit(hit), .outcome(outcome),
  .syn_class(syn_class), .mem_offset(mem_offset), .wdata(wdata),
  .rdata(rdata), .base_l1(base_l1), .base_l2(base_l2)
);

// File: tb/vbase_access_ctl_tb.sv
module vbase_access_ctl_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] LOW_MASK = 64'hFFFF_FFFF_FFFF_F800;

  logic clk = 1'b0;
  logic rst_n;
  logic acc_valid, acc_write, host_mode, lvl2_en, fgt_impl, lvl3_present;
  logic lvl3_fgt_en, fg_rd_trap, fg_wr_trap;
  logic [1:0]  enc_op0, cur_lvl;
  logic [2:0]  enc_op1, enc_op2, nv_bits;
  logic [3:0]  enc_crn, enc_crm;
  logic [63:0] wdata, rdata, base_l1, base_l2;
  logic        hit;
  logic [4:0]  outcome;
  logic [5:0]  syn_class;
  logic [11:0] mem_offset;

  int n_chk = 0;
  int n_bad = 0;
  logic [63:0] m_l1, m_l2;

  always #(CLK_PERIOD/2) clk = ~clk;

  vbase_access_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .enc_op0(enc_op0), .enc_op1(enc_op1), .enc_crn(enc_crn), .enc_crm(enc_crm),
    .enc_op2(enc_op2), .cur_lvl(cur_lvl), .host_mode(host_mode),
    .nv_bits(nv_bits), .lvl2_en(lvl2_en), .fgt_impl(fgt_impl),
    .lvl3_present(lvl3_present), .lvl3_fgt_en(lvl3_fgt_en),
    .fg_rd_trap(fg_rd_trap), .fg_wr_trap(fg_wr_trap), .wdata(wdata),
    .hit(hit), .outcome(outcome), .syn_class(syn_class),
    .mem_offset(mem_offset), .rdata(rdata), .base_l1(base_l1), .base_l2(base_l2)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference: 0 undef, 1 trap, 2 mem, 3 level-2 register, 4 direct
  function automatic logic [4:0] ref_oc();
    logic main, alt, gate, fire;
    main = acc_valid && enc_op0 == 2'b11 && enc_op1 == 3'b000 && enc_crn == 4'hC &&
           enc_crm == 4'h0 && enc_op2 == 3'b000;
    alt  = acc_valid && enc_op0 == 2'b11 && enc_op1 == 3'b101 && enc_crn == 4'hC &&
           enc_crm == 4'h0 && enc_op2 == 3'b000;
    gate = lvl2_en && fgt_impl && (!lvl3_present || lvl3_fgt_en);
    fire = gate && (acc_write ? fg_wr_trap : fg_rd_trap);
    if (!main && !alt) return 5'b00000;
    if (cur_lvl == 2'd0) return 5'b00001;
    if (cur_lvl == 2'd1 && main) begin
      if (nv_bits == 3'b011) return 5'b00010;
      if (fire) return 5'b00010;
      if (nv_bits == 3'b111) return 5'b00100;
      return 5'b10000;
    end
    if (cur_lvl == 2'd1) begin
      if (nv_bits == 3'b101) return 5'b00100;
      if (nv_bits[0]) return 5'b00010;
      return 5'b00001;
    end
    if (main && cur_lvl == 2'd3) return 5'b10000;
    if (main) return host_mode ? 5'b01000 : 5'b10000;
    return host_mode ? 5'b10000 : 5'b00001;
  endfunction

  function automatic string tag_of(input logic [4:0] exp);
    if (exp == 5'b0) return "R1";
    if (cur_lvl == 2'd0) return "R3";
    if (cur_lvl == 2'd1 && enc_op1 == 3'b000) return "R4 R5";
    if (cur_lvl == 2'd1) return "R6";
    if (enc_op1 == 3'b101) return "R8";
    if (cur_lvl == 2'd3) return "R9";
    return "R7";
  endfunction

  task automatic set_idle();
    acc_valid = 0; acc_write = 0; enc_op0 = 2'b11; enc_op1 = 0; enc_crn = 4'hC;
    enc_crm = 0; enc_op2 = 0; cur_lvl = 0; host_mode = 0; nv_bits = 0;
    lvl2_en = 0; fgt_impl = 0; lvl3_present = 0; lvl3_fgt_en = 0;
    fg_rd_trap = 0; fg_wr_trap = 0; wdata = 0;
  endtask

  // Inputs are already set at a negedge; check outputs, step one edge, check registers
  task automatic run_access();
    logic [4:0] exp;
    logic [63:0] exp_rd;
    exp = ref_oc();
    #1;
    check(tag_of(exp), {59'b0, outcome}, {59'b0, exp});
    check("R2", 64'($countones(outcome) <= 1), 64'd1);
    check("R1 hit", {63'b0, hit}, {63'b0, exp != 0});
    check("R10 syn", {58'b0, syn_class}, exp[1] ? 64'h18 : 64'h0);
    check("R10 mem", {52'b0, mem_offset}, exp[2] ? 64'h250 : 64'h0);
    exp_rd = 0;
    if (!acc_write && exp[4]) exp_rd = m_l1;
    if (!acc_write && exp[3]) exp_rd = m_l2;
    check("R13 rdata", rdata, exp_rd);
    if (acc_write && exp[4]) m_l1 = wdata & LOW_MASK;
    if (acc_write && exp[3]) m_l2 = wdata & LOW_MASK;
    @(negedge clk);
    check("R11 l1", base_l1, m_l1);
    check("R11 l2", base_l2, m_l2);
  endtask

  task automatic directed(input logic [1:0] lv, input logic [2:0] op1, input logic wr,
                          input logic hm, input logic [2:0] nv, input logic g, input logic tb);
    set_idle();
    acc_valid = 1; acc_write = wr; cur_lvl = lv; enc_op1 = op1; host_mode = hm;
    nv_bits = nv; lvl2_en = g; fgt_impl = g; lvl3_present = 1; lvl3_fgt_en = g;
    fg_rd_trap = tb; fg_wr_trap = tb; wdata = {$urandom(), $urandom()};
    run_access();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    set_idle();
    rst_n = 0;
    m_l1 = 0; m_l2 = 0;
    repeat (3) @(negedge clk);
    check("R12 l1 reset", base_l1, 64'h0);
    check("R12 l2 reset", base_l2, 64'h0);
    rst_n = 1;
    @(negedge clk);
    // directed corners
    directed(2'd3, 3'b000, 1, 0, 3'b000, 0, 0); // R9 write, loads level-1
    directed(2'd0, 3'b000, 1, 1, 3'b000, 0, 0); // R3
    directed(2'd1, 3'b000, 1, 0, 3'b011, 0, 0); // R4 trap
    directed(2'd1, 3'b000, 1, 0, 3'b111, 1, 1); // R5 wins over redirect
    directed(2'd1, 3'b000, 1, 0, 3'b111, 0, 1); // R4 redirect
    directed(2'd1, 3'b101, 1, 0, 3'b101, 0, 0); // R6 redirect
    directed(2'd1, 3'b101, 0, 0, 3'b010, 0, 0); // R6 undefined
    directed(2'd2, 3'b000, 1, 1, 3'b000, 0, 0); // R7 level-2 register
    directed(2'd2, 3'b000, 0, 1, 3'b000, 0, 0); // R7 read back
    directed(2'd3, 3'b101, 0, 1, 3'b000, 0, 0); // R8 direct read
    directed(2'd2, 3'b101, 1, 0, 3'b000, 0, 0); // R8 undefined
    // random sweep
    for (int i = 0; i < 4000; i++) begin
      set_idle();
      acc_valid = ($urandom_range(0, 9) != 0);
      acc_write = $urandom_range(0, 1);
      enc_op1 = ($urandom_range(0, 1) != 0) ? 3'b000 : 3'b101;
      if ($urandom_range(0, 15) == 0) begin
        enc_op0 = 2'($urandom()); enc_op1 = 3'($urandom()); enc_crn = 4'($urandom());
        enc_crm = 4'($urandom()); enc_op2 = 3'($urandom());
      end
      cur_lvl = 2'($urandom()); host_mode = $urandom_range(0, 1);
      nv_bits = 3'($urandom()); lvl2_en = $urandom_range(0, 1);
      fgt_impl = $urandom_range(0, 1); lvl3_present = $urandom_range(0, 1);
      lvl3_fgt_en = $urandom_range(0, 1); fg_rd_trap = $urandom_range(0, 1);
      fg_wr_trap = $urandom_range(0, 1); wdata = {$urandom(), $urandom()};
      run_access();
    end
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule